// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in physical memory. When the translation buffer misses, it hands the walker the 32-bit virtual address. The walker reads one entry from the first-level table, whose base page comes from the root pointer input. That entry names the page that holds the second-level table, and the walker then reads one entry from it. Table reads go out on a valid/ready request port. Responses come back on a response-valid strobe after any delay. All table accesses use physical addresses; the walker never translates its own reads.

A walk ends in one of two ways. If both entries are present, the walker emits a single-cycle fill pulse that carries the virtual page number, the physical page number and the access permissions, so the buffer can be refilled and the missing access restarted. If either entry is marked not present (the page does not exist, or it lives in secondary storage), the walker emits a single-cycle fault pulse that carries the virtual address and the level that failed, and nothing is filled. Only one walk is in progress at a time.

Top module: `page_walker`

## Requirements
- R1: During reset and in the cycle after it, `miss_ready` is 1 and `mem_req_valid`, `fill_valid` and `fault_valid` are all 0.
- R2: The first read goes to physical address `{root_ppn, 12'h000} + vaddr[31:22]*4`, using the root page captured when the miss is accepted.
- R3: The second read goes to `{P, 12'h000} + vaddr[21:12]*4`, where P is bits 31:12 of the first-level entry.
- R4: A walk in which both entries have bit 0 set ends with one fill pulse. In that pulse, `fill_vpn` = vaddr[31:12], `fill_ppn` = bits 31:12 of the second-level entry, and `fill_perm` = entry bits {3,2,1}, which mean {execute, write, read}. Exactly two reads are issued.
- R5: A first-level entry with bit 0 clear ends the walk with a fault pulse. In that pulse, `fault_level` = 0 and `fault_vaddr` = the missing address. No second read is issued and no fill pulse occurs.
- R6: A second-level entry with bit 0 clear ends the walk with a fault pulse, with `fault_level` = 1 and no fill pulse.
- R7: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` does not change.
- R8: A response strobe that arrives while no read is outstanding has no effect. Responses may arrive any number of cycles after the request is accepted.
- R9: `miss_ready` drops in the cycle after a miss is accepted and stays low until the walk completes.
- R10: `fill_valid` and `fault_valid` are never both 1. Each lasts one cycle, and `miss_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_ready | output | 1 | Walker is idle and accepts a miss |
| root_ppn | input | 20 | Physical page of the first-level table |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 32 | Table entry returned |
| fill_valid | output | 1 | One-cycle pulse: translation found |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_ppn | output | 20 | Physical page number of the fill |
| fill_perm | output | 3 | {execute, write, read} permissions |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | 0 = first-level entry absent, 1 = second-level |
| fault_vaddr | output | 32 | Virtual address that faulted |

## Verification
The checker watches every cycle for the protocol properties. These are the request hold under back-pressure, the busy window after a miss is accepted, completion pulses that are single-cycle and exclusive, the return to ready, the reset state, and stray response strobes being ignored while idle. The properties that depend on the data are shown only by the bench scenarios. These are the addresses formed at each level, the fields copied into a fill, the fault level, and the absence of a second read after a first-level fault. The bench checks them against table contents it builds, under zero and long response latency and with a stalled request port.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PTE_W  = 32;
    localparam int LEVELS = 2;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int PTE_SH = $clog2(PTE_W / 8);
    localparam int PERM_W = 3;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_REQ1,
        WK_WAIT1,
        WK_REQ2,
        WK_WAIT2,
        WK_DONE,
        WK_FAULT
    } walk_state_t;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic              present;
    } entry_t;

    // Entry address for a table at page 'base' and slot 'idx'.
    function automatic logic [PA_W-1:0] slot_addr(input logic [PPN_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        logic [PA_W-1:0] off;
        off = PA_W'(idx) << PTE_SH;
        return {base, {OFF_W{1'b0}}} + off;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int N_LVL = LEVELS
) (
    input  logic [VA_W-1:0]             vaddr,
    input  logic [N_LVL-1:0][PPN_W-1:0] bases,
    input  logic [LVL_W-1:0]            level,
    output logic [PA_W-1:0]             addr
);
    logic [N_LVL-1:0][PA_W-1:0] cand;

    genvar l;
    generate
        for (l = 0; l < N_LVL; l++) begin : g_lvl
            localparam int TOP = VA_W - 1 - l * IDX_W;
            assign cand[l] = slot_addr(bases[l], vaddr[TOP -: IDX_W]);
        end
    endgenerate

    logic offset_unused;
    assign offset_unused = ^vaddr[VA_W-1-N_LVL*IDX_W:0];

    assign addr = cand[level];
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    output entry_t           ent
);
    logic rsvd_unused;
    assign rsvd_unused = ^raw[OFF_W-1:PERM_W+1];

    assign ent.present = raw[0];
    assign ent.perm    = raw[PERM_W:1];
    assign ent.ppn     = raw[PTE_W-1 -: PPN_W];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [PPN_W-1:0]  root_ppn,
    output logic              miss_ready,
    output logic              req_valid,
    output logic [LVL_W-1:0]  req_level,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  entry_t            rsp_ent,
    output logic [VA_W-1:0]   walk_va,
    output logic [PPN_W-1:0]  walk_root,
    output logic [PPN_W-1:0]  walk_next,
    output logic              done_pulse,
    output logic              fault_pulse,
    output logic [LVL_W-1:0]  fault_lvl,
    output entry_t            leaf
);
    walk_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WK_IDLE:  if (miss_valid) st_d = WK_REQ1;
            WK_REQ1:  if (req_ready)  st_d = WK_WAIT1;
            WK_WAIT1: if (rsp_valid)  st_d = rsp_ent.present ? WK_REQ2 : WK_FAULT;
            WK_REQ2:  if (req_ready)  st_d = WK_WAIT2;
            WK_WAIT2: if (rsp_valid)  st_d = rsp_ent.present ? WK_DONE : WK_FAULT;
            WK_DONE:  st_d = WK_IDLE;
            WK_FAULT: st_d = WK_IDLE;
            default:  st_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= WK_IDLE;
            walk_va   <= '0;
            walk_root <= '0;
            walk_next <= '0;
            fault_lvl <= '0;
            leaf      <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == WK_IDLE && miss_valid) begin
                walk_va   <= miss_vaddr;
                walk_root <= root_ppn;
            end
            if (st_q == WK_WAIT1 && rsp_valid) begin
                walk_next <= rsp_ent.ppn;
                fault_lvl <= LVL_W'(0);
            end
            if (st_q == WK_WAIT2 && rsp_valid) begin
                leaf      <= rsp_ent;
                fault_lvl <= LVL_W'(1);
            end
        end
    end

    assign miss_ready  = (st_q == WK_IDLE);
    assign req_valid   = (st_q == WK_REQ1) || (st_q == WK_REQ2);
    assign req_level   = (st_q == WK_REQ2) ? LVL_W'(1) : LVL_W'(0);
    assign done_pulse  = (st_q == WK_DONE);
    assign fault_pulse = (st_q == WK_FAULT);
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [VA_W-1:0]   miss_vaddr,
    output logic              miss_ready,
    input  logic [PPN_W-1:0]  root_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              fill_valid,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PPN_W-1:0]  fill_ppn,
    output logic [PERM_W-1:0] fill_perm,
    output logic              fault_valid,
    output logic [LVL_W-1:0]  fault_level,
    output logic [VA_W-1:0]   fault_vaddr
);
    entry_t                     rsp_ent;
    entry_t                     leaf;
    logic [LVL_W-1:0]           req_level;
    logic [VA_W-1:0]            walk_va;
    logic [PPN_W-1:0]           walk_root;
    logic [PPN_W-1:0]           walk_next;
    logic [LEVELS-1:0][PPN_W-1:0] bases;

    ptw_entry_decode u_dec (
        .raw (mem_rsp_data),
        .ent (rsp_ent)
    );

    ptw_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .miss_valid  (miss_valid),
        .miss_vaddr  (miss_vaddr),
        .root_ppn    (root_ppn),
        .miss_ready  (miss_ready),
        .req_valid   (mem_req_valid),
        .req_level   (req_level),
        .req_ready   (mem_req_ready),
        .rsp_valid   (mem_rsp_valid),
        .rsp_ent     (rsp_ent),
        .walk_va     (walk_va),
        .walk_root   (walk_root),
        .walk_next   (walk_next),
        .done_pulse  (fill_valid),
        .fault_pulse (fault_valid),
        .fault_lvl   (fault_level),
        .leaf        (leaf)
    );

    assign bases[0] = walk_root;
    assign bases[1] = walk_next;

    ptw_addr_gen #(.N_LVL(LEVELS)) u_addr (
        .vaddr (walk_va),
        .bases (bases),
        .level (req_level),
        .addr  (mem_req_addr)
    );

    assign fill_vpn    = walk_va[VA_W-1:OFF_W];
    assign fill_ppn    = leaf.ppn;
    assign fill_perm   = leaf.perm;
    assign fault_vaddr = walk_va;
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk
    import ptw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            miss_valid,
    input logic            miss_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            fill_valid,
    input logic            fault_valid
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (miss_ready && !mem_req_valid && !fill_valid && !fault_valid));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8
    idle_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_ready && !miss_valid && mem_rsp_valid) |=> (miss_ready && !mem_req_valid));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> !miss_ready);

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fill_valid && fault_valid));

    // R10
    fill_once_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> (!fill_valid && miss_ready));

    // R10
    fault_once_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> (!fault_valid && miss_ready));
endmodule

bind page_walker page_walker_chk u_chk (.*);

// File: tb/page_walker_test.sv
`timescale 1ns/1ps
module page_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_vaddr = '0;
    logic        miss_ready;
    logic [19:0] root_ppn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        m_rsp_valid;
    logic [31:0] m_rsp_data;
    logic        spur_valid = 1'b0;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [2:0]  fill_perm;
    logic        fault_valid;
    logic        fault_level;
    logic [31:0] fault_vaddr;

    int total = 0;
    int bad   = 0;
    int lat   = 0;

    always #2.5 clk = ~clk;

    page_walker uut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_ready(miss_ready),
        .root_ppn(root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(m_rsp_valid | spur_valid),
        .mem_rsp_data(spur_valid ? 32'hFFFF_F00F : m_rsp_data),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .fault_valid(fault_valid), .fault_level(fault_level), .fault_vaddr(fault_vaddr)
    );

    // memory model: table contents, accepted-request log, delayed responses
    logic [31:0] pt_mem [logic [31:0]];
    logic [31:0] req_log [0:63];
    int          req_cnt = 0;
    logic        pend;
    int          cnt;
    logic [31:0] paddr;

    always @(posedge clk) begin
        if (rst) begin
            pend        <= 1'b0;
            m_rsp_valid <= 1'b0;
            m_rsp_data  <= '0;
            cnt         <= 0;
            paddr       <= '0;
        end else begin
            m_rsp_valid <= 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    m_rsp_valid <= 1'b1;
                    m_rsp_data  <= pt_mem.exists(paddr) ? pt_mem[paddr] : 32'h0;
                    pend        <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                pend    <= 1'b1;
                cnt     <= lat;
                paddr   <= mem_req_addr;
                req_log[req_cnt % 64] <= mem_req_addr;
                req_cnt <= req_cnt + 1;
            end
        end
    end

    // completion monitor
    int          fills = 0;
    int          faults = 0;
    logic [19:0] cap_vpn, cap_ppn;
    logic [2:0]  cap_perm;
    logic        cap_lvl;
    logic [31:0] cap_fva;
    always @(negedge clk) begin
        if (!rst && fill_valid) begin
            fills   <= fills + 1;
            cap_vpn <= fill_vpn; cap_ppn <= fill_ppn; cap_perm <= fill_perm;
        end
        if (!rst && fault_valid) begin
            faults  <= faults + 1;
            cap_lvl <= fault_level; cap_fva <= fault_vaddr;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] a1_of(input logic [19:0] root, input logic [31:0] va);
        return {root, 12'h000} + {20'h0, va[31:22], 2'b00};
    endfunction
    function automatic logic [31:0] a2_of(input logic [19:0] nxt, input logic [31:0] va);
        return {nxt, 12'h000} + {20'h0, va[21:12], 2'b00};
    endfunction

    // launch a miss, optionally stall the first request, wait for completion
    task automatic run_walk(input logic [31:0] va, input logic [19:0] root,
                            input int stall, output int nreq, output int nfill,
                            output int nfault, output int b_req);
        int b_fill, b_fault, w;
        logic [31:0] held;
        b_req = req_cnt; b_fill = fills; b_fault = faults;
        mem_req_ready = (stall == 0);
        miss_vaddr = va; root_ppn = root; miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        root_ppn = ~root;
        check(miss_ready == 1'b0, "R9", "busy after accept", 32'(miss_ready), 32'h0);
        if (stall > 0) begin
            held = mem_req_addr;
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                check(mem_req_valid && mem_req_addr == held, "R7", "request held under stall",
                      mem_req_addr, held);
            end
            mem_req_ready = 1'b1;
        end
        w = 0;
        while (fills == b_fill && faults == b_fault && w < 500) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        check(miss_ready == 1'b1, "R10", "ready after completion", 32'(miss_ready), 32'h1);
        nreq = req_cnt - b_req; nfill = fills - b_fill; nfault = faults - b_fault;
    endtask

    task automatic t_reset();
        check(miss_ready == 1'b1, "R1", "miss_ready", 32'(miss_ready), 32'h1);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", 32'(mem_req_valid), 32'h0);
        check(fill_valid == 1'b0 && fault_valid == 1'b0, "R1", "pulses",
              {30'h0, fill_valid, fault_valid}, 32'h0);
    endtask

    task automatic t_ok(input logic [31:0] va, input logic [19:0] root, input logic [19:0] nxt,
                        input logic [19:0] ppn, input logic [2:0] perm, input int l, input int stall);
        int nreq, nfill, nfault, b;
        logic [31:0] a1, a2;
        a1 = a1_of(root, va); a2 = a2_of(nxt, va);
        pt_mem[a1] = {nxt, 12'h001};
        pt_mem[a2] = {ppn, 8'h00, perm, 1'b1};
        lat = l;
        run_walk(va, root, stall, nreq, nfill, nfault, b);
        check(nreq == 2, "R4", "read count", 32'(nreq), 32'd2);
        check(req_log[b % 64] == a1, "R2", "first-level address", req_log[b % 64], a1);
        check(req_log[(b + 1) % 64] == a2, "R3", "second-level address", req_log[(b + 1) % 64], a2);
        check(nfill == 1 && nfault == 0, "R4", "one fill no fault", 32'(nfill * 16 + nfault), 32'h10);
        check(cap_vpn == va[31:12], "R4", "fill_vpn", 32'(cap_vpn), 32'(va[31:12]));
        check(cap_ppn == ppn, "R4", "fill_ppn", 32'(cap_ppn), 32'(ppn));
        check(cap_perm == perm, "R4", "fill_perm", 32'(cap_perm), 32'(perm));
    endtask

    task automatic t_fault_l1(input logic [31:0] va, input logic [19:0] root);
        int nreq, nfill, nfault, b;
        pt_mem[a1_of(root, va)] = {20'hABCDE, 12'h00E};
        lat = 1;
        run_walk(va, root, 0, nreq, nfill, nfault, b);
        check(nreq == 1, "R5", "no second read", 32'(nreq), 32'd1);
        check(nfault == 1 && nfill == 0, "R5", "fault only", 32'(nfill * 16 + nfault), 32'h1);
        check(cap_lvl == 1'b0, "R5", "fault_level", 32'(cap_lvl), 32'h0);
        check(cap_fva == va, "R5", "fault_vaddr", cap_fva, va);
    endtask

    task automatic t_fault_l2(input logic [31:0] va, input logic [19:0] root, input logic [19:0] nxt);
        int nreq, nfill, nfault, b;
        pt_mem[a1_of(root, va)] = {nxt, 12'h001};
        pt_mem[a2_of(nxt, va)] = {20'h12345, 12'h00E};
        lat = 3;
        run_walk(va, root, 0, nreq, nfill, nfault, b);
        check(nreq == 2, "R6", "two reads", 32'(nreq), 32'd2);
        check(nfault == 1 && nfill == 0, "R6", "fault only", 32'(nfill * 16 + nfault), 32'h1);
        check(cap_lvl == 1'b1, "R6", "fault_level", 32'(cap_lvl), 32'h1);
        check(cap_fva == va, "R6", "fault_vaddr", cap_fva, va);
    endtask

    task automatic t_stray();
        int b_req, b_fill, b_fault;
        b_req = req_cnt; b_fill = fills; b_fault = faults;
        spur_valid = 1'b1;
        @(negedge clk);
        spur_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(miss_ready == 1'b1 && mem_req_valid == 1'b0, "R8", "idle after stray response",
              {30'h0, miss_ready, mem_req_valid}, 32'h2);
        check(req_cnt == b_req && fills == b_fill && faults == b_fault, "R8", "no activity",
              32'(req_cnt - b_req + fills - b_fill + faults - b_fault), 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ok(32'h1234_5678, 20'h00100, 20'h00200, 20'hCAFE1, 3'b011, 0, 0);
        t_ok(32'hFFFF_F000, 20'hFFFFF, 20'h80000, 20'h00001, 3'b111, 20, 0);
        t_ok(32'h0000_0ABC, 20'h00000, 20'h7FFFF, 20'hFFFFF, 3'b100, 2, 5);
        t_fault_l1(32'h4040_2000, 20'h00321);
        t_fault_l2(32'h8000_1000, 20'h00055, 20'h00066);
        t_stray();
        t_ok(32'h0040_1004, 20'h00400, 20'h00500, 20'h0BEEF, 3'b001, 7, 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule